// File: doc/BRIEF.md
# SPI Flash Byte Program Sequencer

This block takes single-byte program requests and whole-device erase requests from a host and runs them on a serial flash over an SPI bus. No further host action is needed once a request is in. A level input grants permission to modify the flash. While that input is low, requests are dropped and the bus stays quiet.

For each accepted request, the block drives a chain of bus instructions in a fixed order. It first sends a write-enable. Next it sends either the program instruction, with a 24-bit address and the data byte, or the chip-erase instruction. It then reads the flash status register, repeating the read for as long as the flash reports that it is still working. The `busy` output rises on the clock edge that accepts the request. It falls only when a status read shows the flash is idle. The host must see `busy` low before it offers the next byte.

Top module: `spi_flash_prog_seq`

## Requirements
- R1: A byte write or erase request made while `prog_en` is low is ignored: `busy` stays low and `spi_cs_n` never goes low.
- R2: With `prog_en` high and `busy` low, a request on `byte_wr` or `erase_req` is accepted at that clock edge, and `busy` reads 1 from the next cycle.
- R3: A request made while `busy` is high is ignored, and the operation in progress completes with its original address, data and kind.
- R4: The first instruction of every accepted operation is a write-enable: 8 bits, opcode 0x06.
- R5: For a byte write, the second instruction is 40 bits long: opcode 0x02, then the 24-bit address MSB first, then the data byte MSB first.
- R6: After the program or erase instruction, the block sends status reads. Each is 16 bits long: opcode 0x05 followed by 8 clocks in which the status byte is read. It repeats them for as long as bit 0 of the returned status is 1.
- R7: `busy` falls only at the end of a status read that returned bit 0 equal to 0, and at no earlier point.
- R8: For an erase, the second instruction is the 8-bit opcode 0xC7, followed by the status reads of R6.
- R9: When `byte_wr` and `erase_req` are both asserted in the accepted cycle, the erase is performed.
- R10: The bus uses SPI mode 0 at one quarter of the system clock. `spi_sck` is low whenever `spi_cs_n` is high, and rising `spi_sck` edges within an instruction are 4 system clocks apart. Bytes go out MSB first.
- R11: Between instructions, `spi_cs_n` stays high for at least `GAP_CYC` (at least 4) system clocks, which is one SPI clock or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_en | input | 1 | Program/erase permission level |
| byte_wr | input | 1 | Byte write request pulse |
| erase_req | input | 1 | Whole-device erase request pulse |
| byte_addr | input | 24 | Flash byte address for a write |
| byte_data | input | 8 | Data byte for a write |
| busy | output | 1 | Operation in progress |
| spi_sck | output | 1 | SPI serial clock |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The bench builds the block with its default `GAP_CYC` of 4, the shortest gap allowed, so the one-SPI-clock separation is checked at its boundary. Its flash model returns the in-progress status for 3 polls after a program and for 6 polls after an erase. Repeated polling is therefore exercised for both operation kinds, and so is the exact edge at which `busy` falls. A behavioural busy prediction and the mode 0 bus rules are compared on every clock.

// File: rtl/spi_flash_prog_seq.sv
module spi_flash_prog_seq #(
  parameter int GAP_CYC = 4,
  parameter int ADDR_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_en,
  input  logic              byte_wr,
  input  logic              erase_req,
  input  logic [ADDR_W-1:0] byte_addr,
  input  logic [7:0]        byte_data,
  output logic              busy,
  output logic              spi_sck,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int FW    = 16 + ADDR_W;
  localparam int CNT_W = $clog2(FW + 1);
  localparam int GW    = $clog2(GAP_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_WREN, S_OP, S_RDSR} st_t;

  st_t               st;
  logic              erase_q, act;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q, rx;
  logic [1:0]        ph;
  logic [CNT_W-1:0]  nbits, flen;
  logic [FW-1:0]     shreg, frame;
  logic [GW-1:0]     gap;

  assign busy     = (st != S_IDLE);
  assign spi_cs_n = !act;
  assign spi_sck  = act & ph[1];
  assign spi_mosi = act & shreg[FW-1];

  always_comb begin
    frame = '0;
    flen  = CNT_W'(8);
    case (st)
      S_WREN: frame[FW-1 -: 8] = 8'h06;
      S_OP: begin
        if (erase_q) frame[FW-1 -: 8] = 8'hC7;
        else begin
          frame = {8'h02, addr_q, data_q};
          flen  = CNT_W'(FW);
        end
      end
      default: begin
        frame[FW-1 -: 8] = 8'h05;
        flen = CNT_W'(16);
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; erase_q <= 1'b0; addr_q <= '0; data_q <= '0;
      act <= 1'b0; ph <= '0; nbits <= '0; shreg <= '0; rx <= '0; gap <= '0;
    end else if (st == S_IDLE) begin
      if (prog_en && (byte_wr || erase_req)) begin
        st      <= S_WREN;
        erase_q <= erase_req;
        addr_q  <= byte_addr;
        data_q  <= byte_data;
        gap     <= GW'(GAP_CYC);
      end
    end else if (!act) begin
      if (gap != '0) gap <= gap - 1'b1;
      else begin
        act   <= 1'b1;
        ph    <= '0;
        shreg <= frame;
        nbits <= flen;
      end
    end else begin
      ph <= ph + 2'd1;
      if (ph == 2'd2) rx <= {rx[6:0], spi_miso};
      if (ph == 2'd3) begin
        shreg <= {shreg[FW-2:0], 1'b0};
        nbits <= nbits - 1'b1;
        if (nbits == CNT_W'(1)) begin
          act <= 1'b0;
          gap <= GW'(GAP_CYC);
          case (st)
            S_WREN:  st <= S_OP;
            S_OP:    st <= S_RDSR;
            default: st <= rx[0] ? S_RDSR : S_IDLE;
          endcase
        end
      end
    end
  end

  a_r1_gate_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !prog_en && (byte_wr || erase_req)) |=> !busy);

  a_r2_busy_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && prog_en && (byte_wr || erase_req)) |=> busy);

  a_r3_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (byte_wr || erase_req)) |=> ($stable(addr_q) && $stable(data_q) && $stable(erase_q)));

  a_r6_frame_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> busy);

  a_r7_clear_after_idle_poll: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(st) == S_RDSR && !$past(rx[0])));

  a_r11_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |=> spi_cs_n);
endmodule

// File: tb/sim_spi_flash_prog_seq.sv
`timescale 1ns/1ps
module sim_spi_flash_prog_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic prog_en = 1'b0, byte_wr = 1'b0, erase_req = 1'b0;
  logic [23:0] byte_addr = '0;
  logic [7:0]  byte_data = '0;
  logic busy, spi_sck, spi_cs_n, spi_mosi;
  logic spi_miso = 1'b0;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  spi_flash_prog_seq u0 (
    .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .byte_wr(byte_wr),
    .erase_req(erase_req), .byte_addr(byte_addr), .byte_data(byte_data),
    .busy(busy), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural flash model
  int bitc = 0, wip = 0, done_cnt = 0, acc_cnt = 0, cs_falls = 0;
  bit wel = 0, sent_busy = 0, fresh = 1;
  logic [39:0] rxsh = '0;
  logic [7:0]  stat_sh = '0;
  int log_bits[$];
  logic [39:0] log_val[$];
  longint last_rise = 0;

  always @(negedge spi_cs_n) begin
    bitc = 0; rxsh = '0; fresh = 1; cs_falls++;
  end

  always @(posedge spi_sck) begin
    if (!fresh) chk(($time - last_rise) == 40, "R10 sck period", $time - last_rise, 40);
    fresh = 0; last_rise = $time;
    rxsh = {rxsh[38:0], spi_mosi};
    bitc++;
    if (bitc == 8 && rxsh[7:0] == 8'h05) begin
      sent_busy = (wip > 0);
      stat_sh = {7'b0, sent_busy};
    end
  end

  always @(negedge spi_sck) if (bitc >= 8) begin
    spi_miso = stat_sh[7];
    stat_sh = {stat_sh[6:0], 1'b0};
  end

  always @(posedge spi_cs_n) if (rst_n && bitc > 0) begin
    logic [7:0] op;
    op = 8'(rxsh >> (bitc - 8));
    log_bits.push_back(bitc);
    log_val.push_back(rxsh);
    if (op == 8'h06 && bitc == 8) wel = 1;
    else if (op == 8'h02 && bitc == 40 && wel) begin wip = 3; wel = 0; end
    else if (op == 8'hC7 && bitc == 8 && wel) begin wip = 6; wel = 0; end
    else if (op == 8'h05 && bitc == 16) begin
      if (sent_busy) wip--; else done_cnt++;
    end
  end

  // predicted busy, compared every clock
  always @(posedge clk)
    if (rst_n && acc_cnt == done_cnt && prog_en && (byte_wr || erase_req)) acc_cnt++;

  int hi_cnt = 0;
  logic prev_cs = 1'b1;
  always @(negedge clk) if (rst_n) begin
    chk(busy == (acc_cnt != done_cnt), "R2/R7 busy vs model", busy, acc_cnt != done_cnt);
    if (spi_cs_n) chk(!spi_sck, "R10 sck idle low", spi_sck, 0);
    if (spi_cs_n) hi_cnt++;
    else if (prev_cs) begin
      chk(hi_cnt >= 4, "R11 cs high gap", hi_cnt, 4);
      hi_cnt = 0;
    end
    prev_cs = spi_cs_n;
  end

  task automatic request(input bit er, input bit bw, input logic [23:0] a, input logic [7:0] d);
    @(negedge clk);
    erase_req = er; byte_wr = bw; byte_addr = a; byte_data = d;
    @(negedge clk);
    erase_req = 0; byte_wr = 0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 20000) begin @(negedge clk); n++; end
  endtask

  task automatic check_seq(input bit er, input logic [23:0] a, input logic [7:0] d, input string rq);
    int polls;
    polls = er ? 7 : 4;
    chk(log_bits.size() == 2 + polls, {rq, " instruction count"}, log_bits.size(), 2 + polls);
    if (log_bits.size() == 2 + polls) begin
      chk(log_bits[0] == 8 && log_val[0][7:0] == 8'h06, "R4 write enable first", log_val[0][7:0], 8'h06);
      if (er) chk(log_bits[1] == 8 && log_val[1][7:0] == 8'hC7, "R8 chip erase", log_val[1][7:0], 8'hC7);
      else chk(log_bits[1] == 40 && log_val[1] == {8'h02, a, d}, "R5 program frame", log_val[1], {8'h02, a, d});
      for (int i = 2; i < 2 + polls; i++)
        chk(log_bits[i] == 16 && log_val[i][15:8] == 8'h05, "R6 status read", log_val[i][15:0], 16'h0500);
    end
    log_bits.delete(); log_val.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && spi_cs_n && !spi_sck, "reset state", {busy, spi_cs_n, spi_sck}, 3'b010);

    // R1: disabled requests
    request(0, 1, 24'h001234, 8'h55);
    request(1, 0, 24'h0, 8'h0);
    repeat (20) @(negedge clk);
    chk(!busy, "R1 busy stays low", busy, 0);
    chk(cs_falls == 0, "R1 no bus activity", cs_falls, 0);
    chk(log_bits.size() == 0, "R1 no instruction", log_bits.size(), 0);

    prog_en = 1;
    // several byte writes, R2 explicit
    for (int k = 0; k < 3; k++) begin
      logic [23:0] a; logic [7:0] d;
      a = 24'hA5C3F0 ^ (24'h13579B * k);
      d = 8'h81 + 8'(k * 37);
      request(0, 1, a, d);
      chk(busy, "R2 busy after accept", busy, 1);
      wait_idle();
      check_seq(0, a, d, "R5");
    end

    // R3: request while busy
    request(0, 1, 24'hFFFFFF, 8'h00);
    repeat (6) @(negedge clk);
    request(1, 1, 24'h123456, 8'hEE);
    wait_idle();
    check_seq(0, 24'hFFFFFF, 8'h00, "R3");

    // R8 erase
    request(1, 0, 24'h0, 8'h0);
    wait_idle();
    check_seq(1, 24'h0, 8'h0, "R8");

    // R9 simultaneous: erase wins
    request(1, 1, 24'h0F0F0F, 8'h3C);
    wait_idle();
    check_seq(1, 24'h0, 8'h0, "R9");

    // R7: busy held through polls until idle status
    chk(wip == 0 && !busy, "R7 idle after final poll", busy, 0);

    repeat (10) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule